// File: doc/BRIEF.md
# DDR2 Command Timing Checker

This block sits beside a DDR2 memory controller, or in a testbench, and watches the decoded command stream on the memory clock. At most one command is sampled per clock, together with its bank address. The block tracks whether each of the eight banks is open or closed. It keeps saturating clock counters from the earlier commands that constrain later ones. When a command breaks a spacing rule, or does not suit the current bank state, it reports one violation on the next clock, tagged with a rule number.

Every limit is a parameter counted in whole clocks. The defaults assume a 2.5 ns clock, with the nanosecond figures rounded up. The write-to-read and write-recovery limits are counted from the write command itself, so their defaults already include the write latency and the burst transfer time. A command that breaks a rule is still treated as issued: it updates bank state and restarts its timers like a legal command.

Top module: `ddr2_cmd_timing_checker`

## Requirements
- R1: Commands use `cmd` codes 0 none, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge all, 6 refresh, 7 mode load, 8 self-refresh entry, 9 self-refresh exit; codes 10 to 15 act as none. Four cases are state errors, reported as code 1: a read or write to a closed bank, an activate to an open bank, and a refresh or self-refresh entry while any bank is open.
- R2: A read or write less than T_RCD (6) clocks after that bank's activate gives code 2.
- R3: An activate less than T_RP (6) clocks after that bank's last bank precharge, or less than T_RPA (7) clocks after a precharge-all, gives code 3. A bank precharge to a closed bank still restarts that timer.
- R4: An activate less than T_RRD (3) clocks after any earlier activate gives code 4.
- R5: An activate that would be the fifth inside a T_FAW (15) clock window gives code 5. This happens when the fourth most recent activate is fewer than 15 clocks old.
- R6: A bank precharge, or a precharge-all, reaching an open bank less than T_RAS (18) clocks after its activate gives code 6.
- R7: An activate less than T_RC (24) clocks after the previous activate of the same bank gives code 7.
- R8: A read or write less than T_CCD (2) clocks after any read or write gives code 8.
- R9: A read less than T_WTR (10) clocks after any write command gives code 9.
- R10: A precharge reaching an open bank less than T_WR (13) clocks after that bank's last write gives code 10.
- R11: A precharge reaching an open bank less than T_RTP (3) clocks after that bank's last read gives code 11.
- R12: An activate or refresh less than T_RFC (51) clocks after a refresh or a self-refresh exit gives code 12.
- R13: A mode load less than T_MRD (2) clocks after the previous mode load gives code 13.
- R14: `viol` and `viol_code` are registered, so they answer for the command sampled on the previous edge. `viol` is high exactly when the code is nonzero. When several rules break at once, the lowest code is reported. Reset closes all banks and saturates every counter, so the first command after reset has no timing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Decoded command code |
| bank | input | 3 | Bank address for bank-specific commands |
| viol | output | 1 | One-clock pulse for a broken rule |
| viol_code | output | 4 | Lowest broken rule number, 0 when clean |

## Verification
The bench goes after exact boundaries: precharge at 18 clocks, re-activate at 6 clocks after precharge with the bank cycle at exactly 24, and a fifth activate exactly 15 clocks after the fourth-previous one. A design comparing with `<=` instead of `<` would flag these legal commands, and one that does not shift rejected activates into the window would miss the second window error. Overlapping breaks check the priority order: state ahead of bank cycle, write recovery ahead of read-to-precharge, and state ahead of refresh spacing. A wrong order would report the higher code. A precharge-all must add its extra clock, and a self-refresh exit must restart refresh spacing. A design that ignores either would pass an activate that should be flagged.

// File: rtl/ddr2chk_pkg.sv
package ddr2chk_pkg;

  localparam int NRULE = 13;

  typedef logic [3:0]       cmd_t;
  typedef logic [NRULE:1]   rule_vec_t;

  localparam cmd_t CMD_NOP  = 4'd0;
  localparam cmd_t CMD_ACT  = 4'd1;
  localparam cmd_t CMD_RD   = 4'd2;
  localparam cmd_t CMD_WR   = 4'd3;
  localparam cmd_t CMD_PRE  = 4'd4;
  localparam cmd_t CMD_PREA = 4'd5;
  localparam cmd_t CMD_REF  = 4'd6;
  localparam cmd_t CMD_LMR  = 4'd7;
  localparam cmd_t CMD_SRE  = 4'd8;
  localparam cmd_t CMD_SRX  = 4'd9;

  // Rule numbers double as priority: lowest set bit wins.
  localparam int R_STATE = 1;
  localparam int R_RCD   = 2;
  localparam int R_RP    = 3;
  localparam int R_RRD   = 4;
  localparam int R_FAW   = 5;
  localparam int R_RAS   = 6;
  localparam int R_RC    = 7;
  localparam int R_CCD   = 8;
  localparam int R_WTR   = 9;
  localparam int R_WR    = 10;
  localparam int R_RTP   = 11;
  localparam int R_RFC   = 12;
  localparam int R_MRD   = 13;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Lowest-numbered rule that fired, 0 when none.
  function automatic logic [3:0] first_rule(input rule_vec_t v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = NRULE; i >= 1; i--) begin
      if (v[i]) r = 4'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/ddr2chk_gap.sv
// Saturating clocks-since counter for one global spacing rule.
module ddr2chk_gap #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic probe,
  output logic early
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= TOP;
    else if (fire)      cnt <= CW'(1);
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign early = probe && (cnt < TOP);
endmodule

// File: rtl/ddr2chk_faw.sv
// Ages of the most recent N_ACT activates; a new activate is early when
// the oldest of them is still inside the window.
module ddr2chk_faw #(
  parameter int unsigned T_FAW = 15,
  parameter int unsigned N_ACT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic early
);
  localparam int unsigned CW = $clog2(T_FAW + 1);
  localparam logic [CW-1:0] TOP = CW'(T_FAW);

  logic [CW-1:0] age [N_ACT];

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_ACT); i++) age[i] <= TOP;
    end else if (act) begin
      age[0] <= CW'(1);
      for (int i = 1; i < int'(N_ACT); i++) age[i] <= bump(age[i-1]);
    end else begin
      for (int i = 0; i < int'(N_ACT); i++) age[i] <= bump(age[i]);
    end
  end

  assign early = act && (age[N_ACT-1] < TOP);
endmodule

// File: rtl/ddr2chk_bank.sv
// Open/closed state and per-bank spacing timers for one bank.
module ddr2chk_bank
  import ddr2chk_pkg::*;
#(
  parameter int unsigned T_RCD = 6,
  parameter int unsigned T_RP  = 6,
  parameter int unsigned T_RPA = 7,
  parameter int unsigned T_RAS = 18,
  parameter int unsigned T_RC  = 24,
  parameter int unsigned T_WR  = 13,
  parameter int unsigned T_RTP = 3,
  parameter int unsigned CAP   = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  cmd_t      cmd,
  output logic      is_open,
  output rule_vec_t hits
);
  localparam int unsigned CW = $clog2(CAP + 1);
  localparam logic [CW-1:0] TOP = CW'(CAP);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  function automatic logic below(input logic [CW-1:0] v, input int unsigned lim);
    return 32'(v) < lim;
  endfunction

  logic [CW-1:0] since_act, since_pre, since_rd, since_wr;
  logic          open_q, pre_all_q;

  logic c_act, c_rd, c_wr, c_pre, c_prea, c_needidle, c_close;
  assign c_act      = sel && (cmd == CMD_ACT);
  assign c_rd       = sel && (cmd == CMD_RD);
  assign c_wr       = sel && (cmd == CMD_WR);
  assign c_pre      = sel && (cmd == CMD_PRE);
  assign c_prea     = sel && (cmd == CMD_PREA);
  assign c_needidle = sel && ((cmd == CMD_REF) || (cmd == CMD_SRE));
  assign c_close    = c_pre || c_prea;

  int unsigned rp_lim;
  assign rp_lim = pre_all_q ? T_RPA : T_RP;

  always_comb begin
    hits          = '0;
    hits[R_STATE] = (c_act && open_q) || ((c_rd || c_wr) && !open_q) ||
                    (c_needidle && open_q);
    hits[R_RCD]   = (c_rd || c_wr) && below(since_act, T_RCD);
    hits[R_RP]    = c_act && below(since_pre, rp_lim);
    hits[R_RAS]   = c_close && open_q && below(since_act, T_RAS);
    hits[R_RC]    = c_act && below(since_act, T_RC);
    hits[R_WR]    = c_close && open_q && below(since_wr, T_WR);
    hits[R_RTP]   = c_close && open_q && below(since_rd, T_RTP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      pre_all_q <= 1'b0;
      since_act <= TOP;
      since_pre <= TOP;
      since_rd  <= TOP;
      since_wr  <= TOP;
    end else begin
      since_act <= c_act   ? CW'(1) : bump(since_act);
      since_pre <= c_close ? CW'(1) : bump(since_pre);
      since_rd  <= c_rd    ? CW'(1) : bump(since_rd);
      since_wr  <= c_wr    ? CW'(1) : bump(since_wr);
      if (c_act)        open_q <= 1'b1;
      else if (c_close) open_q <= 1'b0;
      if (c_close)      pre_all_q <= c_prea;
    end
  end

  assign is_open = open_q;
endmodule

// File: rtl/ddr2_cmd_timing_checker.sv
module ddr2_cmd_timing_checker
  import ddr2chk_pkg::*;
#(
  parameter int unsigned BA_W  = 3,
  parameter int unsigned T_RCD = 6,
  parameter int unsigned T_RP  = 6,
  parameter int unsigned T_RPA = 7,
  parameter int unsigned T_RRD = 3,
  parameter int unsigned T_FAW = 15,
  parameter int unsigned N_ACT = 4,
  parameter int unsigned T_RAS = 18,
  parameter int unsigned T_RC  = 24,
  parameter int unsigned T_CCD = 2,
  parameter int unsigned T_WTR = 10,
  parameter int unsigned T_WR  = 13,
  parameter int unsigned T_RTP = 3,
  parameter int unsigned T_RFC = 51,
  parameter int unsigned T_MRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd,
  input  logic [BA_W-1:0] bank,
  output logic            viol,
  output logic [3:0]      viol_code
);
  localparam int unsigned NBANK    = 1 << BA_W;
  localparam int unsigned CAP_BANK =
    max2(max2(max2(T_RC, T_RAS), max2(T_RPA, T_RP)),
         max2(max2(T_WR, T_RTP), T_RCD));

  // Decoded command events, named for the assertions.
  logic is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_lmr, is_sre, is_srx;
  assign is_act  = (cmd == CMD_ACT);
  assign is_rd   = (cmd == CMD_RD);
  assign is_wr   = (cmd == CMD_WR);
  assign is_pre  = (cmd == CMD_PRE);
  assign is_prea = (cmd == CMD_PREA);
  assign is_ref  = (cmd == CMD_REF);
  assign is_lmr  = (cmd == CMD_LMR);
  assign is_sre  = (cmd == CMD_SRE);
  assign is_srx  = (cmd == CMD_SRX);

  logic bank_cmd, all_cmd;
  assign bank_cmd = is_act || is_rd || is_wr || is_pre;
  assign all_cmd  = is_prea || is_ref || is_sre;

  logic [NBANK-1:0] open_mask;
  logic [NBANK-1:0] bank_sel;
  rule_vec_t        bank_hits [NBANK];
  rule_vec_t        bank_any;

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    assign bank_sel[b] = (bank_cmd && (bank == BA_W'(b))) || all_cmd;
    ddr2chk_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RPA(T_RPA), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_WR(T_WR), .T_RTP(T_RTP), .CAP(CAP_BANK)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (bank_sel[b]),
      .cmd    (cmd),
      .is_open(open_mask[b]),
      .hits   (bank_hits[b])
    );
  end

  always_comb begin
    bank_any = '0;
    for (int b = 0; b < int'(NBANK); b++) bank_any = bank_any | bank_hits[b];
  end

  // Spacing rules that span all banks.
  logic g_rrd, g_faw, g_ccd, g_wtr, g_rfc, g_mrd;

  ddr2chk_gap #(.LIMIT(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .fire(is_act), .probe(is_act), .early(g_rrd));
  ddr2chk_gap #(.LIMIT(T_CCD)) u_ccd (
    .clk(clk), .rst_n(rst_n), .fire(is_rd || is_wr), .probe(is_rd || is_wr),
    .early(g_ccd));
  ddr2chk_gap #(.LIMIT(T_WTR)) u_wtr (
    .clk(clk), .rst_n(rst_n), .fire(is_wr), .probe(is_rd), .early(g_wtr));
  ddr2chk_gap #(.LIMIT(T_RFC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .fire(is_ref || is_srx), .probe(is_act || is_ref),
    .early(g_rfc));
  ddr2chk_gap #(.LIMIT(T_MRD)) u_mrd (
    .clk(clk), .rst_n(rst_n), .fire(is_lmr), .probe(is_lmr), .early(g_mrd));
  ddr2chk_faw #(.T_FAW(T_FAW), .N_ACT(N_ACT)) u_faw (
    .clk(clk), .rst_n(rst_n), .act(is_act), .early(g_faw));

  rule_vec_t rule_hits;
  always_comb begin
    rule_hits        = bank_any;
    rule_hits[R_RRD] = g_rrd;
    rule_hits[R_FAW] = g_faw;
    rule_hits[R_CCD] = g_ccd;
    rule_hits[R_WTR] = g_wtr;
    rule_hits[R_RFC] = g_rfc;
    rule_hits[R_MRD] = g_mrd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else begin
      viol      <= |rule_hits;
      viol_code <= first_rule(rule_hits);
    end
  end
endmodule

// File: rtl/ddr2_cmd_timing_checker_sva.sv
module ddr2_cmd_timing_checker_sva
  import ddr2chk_pkg::*;
#(
  parameter int unsigned BA_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            cmd,
  input logic [BA_W-1:0]       bank,
  input logic                  viol,
  input logic [3:0]            viol_code,
  input logic [(1<<BA_W)-1:0]  open_mask,
  input rule_vec_t             rule_hits
);
  AST_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 4'd0)); // R14

  AST_HIT_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_hits != '0) |=> viol); // R14

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) |=> !viol); // R14

  AST_COL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD || cmd == CMD_WR) && !open_mask[bank]) |=> (viol_code == 4'd1)); // R1

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> open_mask[$past(bank)]); // R1

  AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PREA) |=> (open_mask == '0)); // R1

  AST_COL_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD || cmd == CMD_WR) && ($past(cmd) == CMD_RD || $past(cmd) == CMD_WR))
    |=> viol); // R8

  AST_ACT_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_ACT) && ($past(cmd) == CMD_ACT)) |=> viol); // R4
endmodule

bind ddr2_cmd_timing_checker ddr2_cmd_timing_checker_sva #(.BA_W(BA_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .bank     (bank),
  .viol     (viol),
  .viol_code(viol_code),
  .open_mask(open_mask),
  .rule_hits(rule_hits)
);

// File: tb/ddr2_cmd_timing_checker_tb.sv
module ddr2_cmd_timing_checker_tb_top;
  import ddr2chk_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cmd;
  logic [2:0] bank;
  logic       viol;
  logic [3:0] viol_code;

  always #2 clk = ~clk;

  ddr2_cmd_timing_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .viol(viol), .viol_code(viol_code)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Driver: one command per clock, expected code queued alongside.
  task automatic issue(input logic [3:0] c, input logic [2:0] b, input int e, input string tag);
    @(negedge clk);
    cmd  = c;
    bank = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(CMD_NOP, 3'd0, 0, "R14");
  endtask

  task automatic settle();
    idle(60);
    issue(CMD_PREA, 3'd0, 0, "R3");
    idle(60);
  endtask

  // Monitor: the registered result for the command sampled at this edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (viol !== (e != 0) || viol_code !== 4'(e)) begin
        n_bad++;
        $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                 t, viol, viol_code, (e != 0), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd   = CMD_NOP;
    bank  = 3'd0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (viol !== 1'b0 || viol_code !== 4'd0) begin
      n_bad++;
      $display("FAIL R14 reset: viol=%0b code=%0d, expected viol=0 code=0", viol, viol_code);
    end
    rst_n = 1'b1;

    // Phase 1: state, RCD, CCD, RAS, RC and priority.
    issue(CMD_ACT, 3'd0, 0, "R14");   // first command after reset
    idle(1);
    issue(CMD_ACT, 3'd0, 1, "R1");    // open bank, beats RRD and RC
    idle(2);
    issue(CMD_RD, 3'd0, 2, "R2");
    idle(5);
    issue(CMD_RD, 3'd0, 0, "R2");
    issue(CMD_RD, 3'd0, 8, "R8");
    issue(CMD_PRE, 3'd0, 6, "R6");    // RAS ahead of RTP
    idle(5);
    issue(CMD_ACT, 3'd0, 7, "R7");    // RP met at 6, RC missed
    settle();

    // Phase 2: RRD, four-activate window, exact boundaries.
    issue(CMD_ACT, 3'd0, 0, "R4");
    idle(1);
    issue(CMD_ACT, 3'd1, 4, "R4");
    idle(2);
    issue(CMD_ACT, 3'd2, 0, "R4");
    idle(2);
    issue(CMD_ACT, 3'd3, 0, "R5");
    idle(2);
    issue(CMD_ACT, 3'd4, 5, "R5");
    idle(2);
    issue(CMD_ACT, 3'd5, 5, "R5");    // rejected activate counted in window
    idle(5);
    issue(CMD_ACT, 3'd6, 0, "R5");    // exactly 15
    idle(2);
    issue(CMD_PRE, 3'd2, 0, "R6");    // exactly 18
    idle(5);
    issue(CMD_ACT, 3'd2, 0, "R3");    // RP exactly 6, RC exactly 24
    settle();

    // Phase 3: write-to-read, write recovery, read-to-precharge.
    issue(CMD_ACT, 3'd1, 0, "R2");
    idle(5);
    issue(CMD_WR, 3'd1, 0, "R2");
    idle(1);
    issue(CMD_RD, 3'd1, 9, "R9");
    idle(7);
    issue(CMD_RD, 3'd1, 0, "R9");
    idle(1);
    issue(CMD_PRE, 3'd1, 10, "R10");  // WR ahead of RTP
    settle();
    issue(CMD_ACT, 3'd1, 0, "R10");
    idle(5);
    issue(CMD_WR, 3'd1, 0, "R10");
    idle(12);
    issue(CMD_PRE, 3'd1, 0, "R10");   // exactly 13
    issue(CMD_RD, 3'd1, 1, "R1");     // closed bank
    settle();
    issue(CMD_ACT, 3'd2, 0, "R11");
    idle(5);
    issue(CMD_RD, 3'd2, 0, "R11");
    idle(9);
    issue(CMD_RD, 3'd2, 0, "R11");
    idle(1);
    issue(CMD_PRE, 3'd2, 11, "R11");
    settle();

    // Phase 4: refresh, precharge-all, mode loads, self-refresh.
    issue(CMD_REF, 3'd0, 0, "R12");
    idle(9);
    issue(CMD_REF, 3'd0, 12, "R12");
    idle(50);
    issue(CMD_ACT, 3'd0, 0, "R12");   // exactly 51
    issue(CMD_REF, 3'd0, 1, "R1");    // bank open
    settle();
    issue(CMD_ACT, 3'd3, 0, "R3");
    idle(59);
    issue(CMD_PREA, 3'd0, 0, "R3");
    idle(5);
    issue(CMD_ACT, 3'd3, 3, "R3");    // 6 < 7 after precharge-all
    settle();
    issue(CMD_LMR, 3'd0, 0, "R13");
    issue(CMD_LMR, 3'd0, 13, "R13");
    idle(1);
    issue(CMD_LMR, 3'd0, 0, "R13");
    issue(CMD_ACT, 3'd4, 0, "R6");
    idle(4);
    issue(CMD_PREA, 3'd0, 6, "R6");
    idle(10);
    issue(CMD_SRE, 3'd0, 0, "R1");
    idle(10);
    issue(CMD_SRX, 3'd0, 0, "R12");
    idle(4);
    issue(CMD_ACT, 3'd0, 12, "R12");
    issue(CMD_SRE, 3'd0, 1, "R1");
    issue(4'hF, 3'd0, 0, "R1");       // unused code acts as none
    idle(3);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule